// File: doc/BRIEF.md
# Trimmable Two-Stage Clock Strobe Generator

This block runs on one fast input clock and derives two enable strobes from it. The first stage makes an internal-rate strobe. That strobe fires on every input cycle or on every second input cycle. The phase of the internal strobe can be trimmed slowly. At a programmable cadence, one internal period is lengthened or shortened by exactly one input cycle. This gives fine frequency or phase correction on top of the plain integer ratio.

The second stage counts internal strobes and fires an output strobe on every D-th one, for D from 1 to 31. A setting of zero silences the output. Both strobes are single-cycle enables in the input clock domain, so downstream logic uses them as clock enables rather than as gated clocks.

All settings come from one 16-bit configuration word. That word carries a two-bit identifier, and a word whose identifier does not match is dropped in full. An accepted word takes effect from the next input cycle.

Top module: `trim_clock_divider`

## Requirements
- R1: A write is accepted only when word bits [15:14] equal 2'b01. A write with any other identifier (00, 10, 11) leaves every setting and both strobe streams unchanged.
- R2: After synchronous active-high reset, the settings are: ratio /2, trim rate 0, direction retard, output divisor 16. The first internal strobe comes on the second cycle after reset is released, and the 16th internal strobe carries the first output strobe.
- R3: Word bit 5 selects the internal ratio: 0 gives an internal strobe on every input cycle, and 1 gives one on every second input cycle.
- R4: Word bits [12:6] hold the trim rate N. N = 0 never alters a period. For N from 1 to 127, exactly one internal period in every N is altered.
- R5: Word bit 13 selects the trim direction: 0 (retard) lengthens the altered period by one input cycle, and 1 (advance) shortens it by one input cycle.
- R6: When advance is selected with the /1 ratio, no period is altered, and the internal strobe stays on every cycle.
- R7: Word bits [4:0] equal to 0 produce no output strobe.
- R8: Word bits [4:0] equal to D (1 to 31) produce one output strobe on every D-th internal strobe.
- R9: An output strobe is only ever asserted in a cycle that also carries an internal strobe.
- R10: Every accepted write restarts the trim cadence. The period that is in progress when the write lands counts as period 1, so the period that ends at the N-th, 2N-th, ... internal strobe after the write is the altered one.
- R11: An accepted write that changes the output divisor discards the old count. The first internal strobe after the write produces no output strobe and restarts the count, so output strobes then fall on internal strobes D+1, 2D+1, ... after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write enable, one cycle |
| cfg_word | input | 16 | Configuration word: identifier [15:14], direction [13], rate [12:6], ratio [5], output divisor [4:0] |
| iclk_stb | output | 1 | Internal-rate enable strobe |
| oclk_stb | output | 1 | Output-rate enable strobe |

## Verification
The hardest situation to reach from the ports is the largest trim cadence. With N = 127, the altered period must land on exactly the 127th and 254th internal strobe after the write, and a plain timing check would never show an off-by-one in that count. To reach it, each configuration write is followed by a recording of every internal and output strobe, indexed from the write edge. Each interval is compared with the value that the requirement predicts for that index. Random settings from a fixed seed are mixed with directed cases: rates 1, 2 and 127, both directions, divisors 1, 2, 16 and 31, and foreign identifiers. The random settings always change the divisor, so the restart alignment is exercised every time.

// File: rtl/trim_clk_pkg.sv
package trim_clk_pkg;

   // Trim direction, as decoded from the configuration word.
   typedef enum logic {
      TRIM_RETARD  = 1'b0,
      TRIM_ADVANCE = 1'b1
   } trim_dir_e;

   // Width of the register identifier field at the top of the word.
   localparam int unsigned TRIM_ID_W = 2;

   // Widest internal period: base ratio 2 plus one retard cycle.
   localparam int unsigned TRIM_PHASE_W = 2;

endpackage

// File: rtl/trim_cfg_regs.sv
module trim_cfg_regs
   import trim_clk_pkg::*;
#(
   parameter int unsigned RATE_W    = 7,
   parameter int unsigned ODIV_W    = 5,
   parameter logic [1:0]  ID_VALUE  = 2'b01,
   parameter bit          RATIO_RST = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_en,
   input  logic [ODIV_W+RATE_W+3:0]    wr_word,
   output trim_dir_e                   dir,
   output logic [RATE_W-1:0]           rate,
   output logic                        half,
   output logic [ODIV_W-1:0]           odiv,
   output logic                        rate_clr,
   output logic                        odiv_chg
);

   localparam int unsigned ODIV_LSB  = 0;
   localparam int unsigned RATIO_BIT = ODIV_W;
   localparam int unsigned RATE_LSB  = ODIV_W + 1;
   localparam int unsigned DIR_BIT   = RATE_LSB + RATE_W;
   localparam int unsigned ID_LSB    = DIR_BIT + 1;
   localparam logic [ODIV_W-1:0] ODIV_RST = ODIV_W'(1) << (ODIV_W - 1);

   logic                 accept;
   logic [ODIV_W-1:0]    new_odiv;

   assign accept   = wr_en && (wr_word[ID_LSB +: TRIM_ID_W] == ID_VALUE);
   assign new_odiv = wr_word[ODIV_LSB +: ODIV_W];
   assign rate_clr = accept;
   assign odiv_chg = accept && (new_odiv != odiv);

   always_ff @(posedge clk) begin
      if (rst) begin
         dir  <= TRIM_RETARD;
         rate <= '0;
         half <= RATIO_RST;
         odiv <= ODIV_RST;
      end else if (accept) begin
         dir  <= trim_dir_e'(wr_word[DIR_BIT]);
         rate <= wr_word[RATE_LSB +: RATE_W];
         half <= wr_word[RATIO_BIT];
         odiv <= new_odiv;
      end
   end

   // R1: a word with a foreign identifier leaves every setting alone
   a_r1_foreign_ignored: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_word[ID_LSB +: TRIM_ID_W] != ID_VALUE))
         |=> ($stable(dir) && $stable(rate) && $stable(half) && $stable(odiv)));

endmodule

// File: rtl/trim_adj_sched.sv
module trim_adj_sched #(
   parameter int unsigned RATE_W = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic [RATE_W-1:0] rate,
   input  logic              iclk_stb,
   output logic              adj_due
);

   localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

   logic [RATE_W-1:0] per_cnt;

   // The current internal period is the N-th of the cadence.
   assign adj_due = (rate != '0) && (per_cnt == rate - ONE);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         per_cnt <= '0;
      end else if (iclk_stb) begin
         if (adj_due || (rate == '0)) per_cnt <= '0;
         else                         per_cnt <= per_cnt + ONE;
      end
   end

   // R4: the period counter never passes the programmed cadence
   a_r4_count_below_rate: assert property (@(posedge clk) disable iff (rst)
      (rate != '0) |-> (per_cnt < rate));

   // R10: a write leaves the cadence at its first period
   a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
      clr |=> (per_cnt == '0));

endmodule

// File: rtl/trim_int_div.sv
module trim_int_div
   import trim_clk_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      half,
   input  trim_dir_e dir,
   input  logic      adj_due,
   output logic      iclk_stb
);

   logic [TRIM_PHASE_W-1:0] phase;
   logic [TRIM_PHASE_W-1:0] base_len;
   logic [TRIM_PHASE_W-1:0] cur_len;
   logic                    adj_ok;

   always_comb begin
      base_len = half ? 2'd2 : 2'd1;
      // advance cannot shorten a one-cycle period
      adj_ok   = adj_due && !((dir == TRIM_ADVANCE) && !half);
      if (!adj_ok)                  cur_len = base_len;
      else if (dir == TRIM_RETARD)  cur_len = base_len + 2'd1;
      else                          cur_len = base_len - 2'd1;
   end

   // >= also closes a period at once when a write shortens it mid-way
   assign iclk_stb = (phase >= cur_len - 2'd1);

   always_ff @(posedge clk) begin
      if (rst)           phase <= '0;
      else if (iclk_stb) phase <= '0;
      else               phase <= phase + 2'd1;
   end

   // R5: no internal period exceeds base ratio plus one retard cycle
   a_r5_phase_bound: assert property (@(posedge clk) disable iff (rst)
      phase <= 2'd2);

   // R6: advance at ratio /1 keeps the strobe on every cycle
   a_r6_no_advance_at_one: assert property (@(posedge clk) disable iff (rst)
      (!half && (dir == TRIM_ADVANCE)) |-> iclk_stb);

endmodule

// File: rtl/trim_out_div.sv
module trim_out_div #(
   parameter int unsigned ODIV_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ODIV_W-1:0] odiv,
   input  logic              restart_req,
   input  logic              iclk_stb,
   output logic              oclk_stb
);

   localparam logic [ODIV_W-1:0] ONE = ODIV_W'(1);

   logic [ODIV_W-1:0] ocnt;
   logic              pending;

   assign oclk_stb = iclk_stb && !pending && (odiv != '0) && (ocnt == odiv - ONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         ocnt    <= '0;
         pending <= 1'b0;
      end else if (restart_req) begin
         pending <= 1'b1;
      end else if (iclk_stb) begin
         if (pending || (odiv == '0)) begin
            pending <= 1'b0;
            ocnt    <= '0;
         end else if (ocnt == odiv - ONE) begin
            ocnt    <= '0;
         end else begin
            ocnt    <= ocnt + ONE;
         end
      end
   end

   // R7: a zero divisor silences the output
   a_r7_off_quiet: assert property (@(posedge clk) disable iff (rst)
      (odiv == '0) |-> !oclk_stb);

   // R11: the strobe after a divisor change never fires the output
   a_r11_no_runt: assert property (@(posedge clk) disable iff (rst)
      $past(restart_req) |-> !oclk_stb);

endmodule

// File: rtl/trim_clock_divider.sv
module trim_clock_divider
   import trim_clk_pkg::*;
#(
   parameter int unsigned RATE_W   = 7,
   parameter int unsigned ODIV_W   = 5,
   parameter logic [1:0]  ID_VALUE = 2'b01
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cfg_wr,
   input  logic [ODIV_W+RATE_W+3:0] cfg_word,
   output logic                     iclk_stb,
   output logic                     oclk_stb
);

   if (RATE_W < 1 || RATE_W > 16) begin : g_bad_rate
      $error("trim_clock_divider: RATE_W out of range");
   end
   if (ODIV_W < 1 || ODIV_W > 16) begin : g_bad_odiv
      $error("trim_clock_divider: ODIV_W out of range");
   end

   trim_dir_e          dir;
   logic [RATE_W-1:0]  rate;
   logic               half;
   logic [ODIV_W-1:0]  odiv;
   logic               rate_clr;
   logic               odiv_chg;
   logic               adj_due;

   trim_cfg_regs #(
      .RATE_W   (RATE_W),
      .ODIV_W   (ODIV_W),
      .ID_VALUE (ID_VALUE),
      .RATIO_RST(1'b1)
   ) i_cfg (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_wr),
      .wr_word (cfg_word),
      .dir     (dir),
      .rate    (rate),
      .half    (half),
      .odiv    (odiv),
      .rate_clr(rate_clr),
      .odiv_chg(odiv_chg)
   );

   trim_adj_sched #(.RATE_W(RATE_W)) i_sched (
      .clk     (clk),
      .rst     (rst),
      .clr     (rate_clr),
      .rate    (rate),
      .iclk_stb(iclk_stb),
      .adj_due (adj_due)
   );

   trim_int_div i_int (
      .clk     (clk),
      .rst     (rst),
      .half    (half),
      .dir     (dir),
      .adj_due (adj_due),
      .iclk_stb(iclk_stb)
   );

   trim_out_div #(.ODIV_W(ODIV_W)) i_out (
      .clk        (clk),
      .rst        (rst),
      .odiv       (odiv),
      .restart_req(odiv_chg),
      .iclk_stb   (iclk_stb),
      .oclk_stb   (oclk_stb)
   );

   // R9: the output strobe rides on an internal strobe
   a_r9_out_on_int: assert property (@(posedge clk) disable iff (rst)
      oclk_stb |-> iclk_stb);

   // R2: the first cycle after reset carries no internal strobe at ratio /2
   a_r2_reset_phase: assert property (@(posedge clk)
      ($past(rst) && !rst) |-> !iclk_stb);

endmodule

// File: tb/test_trim_clock_divider.sv
module test_trim_clock_divider;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_word = '0;
   logic        iclk_stb;
   logic        oclk_stb;

   int n_chk = 0;
   int n_bad = 0;
   int cyc_total = 0;
   bit done = 0;

   int ivals [0:2047];
   int oidx  [0:255];
   int ni, no, ns;

   always #2.5 clk = ~clk;

   trim_clock_divider i_trim_clock_divider (
      .clk     (clk),
      .rst     (rst),
      .cfg_wr  (cfg_wr),
      .cfg_word(cfg_word),
      .iclk_stb(iclk_stb),
      .oclk_stb(oclk_stb)
   );

   always @(negedge clk) begin
      cyc_total++;
      if (cyc_total > 150000 && !done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc_total);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   function automatic logic [15:0] mk(input int id, input int dir, input int n,
                                      input int half, input int d);
      return {id[1:0], dir[0], n[6:0], half[0], d[4:0]};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] w);
      @(negedge clk);
      cfg_wr   = 1'b1;
      cfg_word = w;
      @(posedge clk);
      #1;
      cfg_wr   = 1'b0;
   endtask

   // Records strobes from the first negedge after the last write edge.
   task automatic observe(input int ncyc);
      int last_i;
      last_i = -1;
      ni = 0; no = 0; ns = 0;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         if (iclk_stb) begin
            ns++;
            if (last_i >= 0 && ni < 2048) begin
               ivals[ni] = c - last_i;
               ni++;
            end
            last_i = c;
         end
         if (oclk_stb) begin
            if (!iclk_stb) chk("R9 output without internal strobe", 1, 0);
            if (no < 256) begin
               oidx[no] = ns;
               no++;
            end
         end
      end
   endtask

   // obase: internal-strobe index the output count starts from, -1 if unknown
   task automatic run_check(input string tag, input int r, input int n, input int dir,
                            input int d, input int obase);
      int ncyc, alen, exp;
      bit aj;
      ncyc = (r + 1) * (2 * (n > 0 ? n : 1) + 2 * (d > 0 ? d : 1) + 6) + 10;
      observe(ncyc);
      aj   = (n != 0) && !(dir == 1 && r == 1);
      alen = dir ? r - 1 : r + 1;
      chk({tag, " enough internal strobes"}, int'(ni >= 2 * (n > 0 ? n : 2)), 1);
      for (int j = 0; j < ni; j++) begin
         // interval j ends at internal strobe j+2 after the write (R4 R5 R10)
         exp = (aj && ((j + 2) % n == 0)) ? alen : r;
         chk({tag, " internal interval R3/R4/R5/R10"}, ivals[j], exp);
      end
      if (d == 0) begin
         chk({tag, " R7 output silent"}, no, 0);
      end else begin
         chk({tag, " R8 output strobes seen"}, int'(no >= 1), 1);
         for (int k = 0; k < no; k++) begin
            if (obase >= 0)
               chk({tag, " R8/R11 output strobe index"}, oidx[k], obase + (k + 1) * d);
            else if (k > 0)
               chk({tag, " R8 output spacing"}, oidx[k] - oidx[k - 1], d);
         end
      end
   endtask

   initial begin
      int prev_d, r, n, dir, d;
      string tag;
      void'($urandom(32'd20240917));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R2: defaults, count starts at reset release
      run_check("R2 reset defaults", 2, 0, 0, 16, 0);

      // R3 R8: ratio /1, divisor 1
      wr(mk(1, 0, 0, 0, 1));  run_check("R3 div1 D1", 1, 0, 0, 1, 1);
      wr(mk(1, 0, 0, 1, 2));  run_check("R8 div2 D2", 2, 0, 0, 2, 1);
      wr(mk(1, 0, 0, 0, 31)); run_check("R8 div1 D31", 1, 0, 0, 31, 1);
      wr(mk(1, 0, 0, 1, 16)); run_check("R8 div2 D16", 2, 0, 0, 16, 1);
      wr(mk(1, 0, 0, 1, 0));  run_check("R7 off", 2, 0, 0, 0, 1);

      // R1: foreign identifiers change nothing
      wr(mk(2, 1, 3, 0, 3)); run_check("R1 id10", 2, 0, 0, 0, -1);
      wr(mk(0, 0, 1, 0, 5)); run_check("R1 id00", 2, 0, 0, 0, -1);
      wr(mk(3, 1, 2, 0, 7)); run_check("R1 id11", 2, 0, 0, 0, -1);

      // R4 R5 R10: cadence in both directions
      wr(mk(1, 0, 1, 1, 3));   run_check("R5 retard N1", 2, 1, 0, 3, 1);
      wr(mk(1, 1, 1, 1, 4));   run_check("R5 advance N1", 2, 1, 1, 4, 1);
      wr(mk(1, 0, 2, 1, 5));   run_check("R4 retard N2", 2, 2, 0, 5, 1);
      wr(mk(1, 1, 2, 1, 6));   run_check("R4 advance N2", 2, 2, 1, 6, 1);
      wr(mk(1, 0, 127, 1, 7)); run_check("R4 retard N127", 2, 127, 0, 7, 1);
      wr(mk(1, 1, 127, 1, 8)); run_check("R4 advance N127", 2, 127, 1, 8, 1);
      wr(mk(1, 0, 3, 0, 9));   run_check("R5 retard div1 N3", 1, 3, 0, 9, 1);
      wr(mk(1, 1, 2, 0, 10));  run_check("R6 advance div1 ignored", 1, 2, 1, 10, 1);
      wr(mk(1, 0, 4, 1, 11));  run_check("R10 cadence restart", 2, 4, 0, 11, 1);
      prev_d = 11;

      // random settings; the divisor always changes so R11 alignment holds
      for (int t = 0; t < 10; t++) begin
         r   = 1 + ($urandom % 2);
         n   = $urandom % 10;
         dir = $urandom % 2;
         do d = 1 + ($urandom % 31); while (d == prev_d);
         prev_d = d;
         $sformat(tag, "rand%0d R11", t);
         wr(mk(1, dir, n, r - 1, d));
         run_check(tag, r, n, dir, d, 1);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule